// File: doc/BRIEF.md
# Three-Phase Bridge Dead-Time Controller

This block produces the six gate-enable signals for a three-phase half-bridge. Each phase has two commands: an active-high low-side request and an active-low high-side request. The phase drives a low-side and a high-side gate enable from them. When the two commands conflict, the low-side command wins. Any output that must go off goes off on the next registered update. Any output that must come on waits a programmable number of clock cycles first, so the two switches of a phase are never both on. A global bypass removes dead-time insertion and priority, and both outputs then follow their commands. Both switches of a phase may then be on together. A disable input and an undervoltage flag each force all six outputs off, whatever the other inputs are.

All command and control inputs pass through a two-flop synchronizer, and every output is a register. An input change therefore reaches the outputs on the third rising clock edge after it is applied. The dead-time length is a cycle count. It is read from its input port only while all six outputs are off, so a length that is already counting is never cut short. The dead-time input is treated as quasi-static and is not synchronized.

Top module: `bridge_deadtime_ctrl`

## Requirements
- R1: During and after reset all six gate outputs are 0, and the stored dead-time length takes the value of parameter DT_RESET.
- R2: With bypass off, a phase whose low command is 1 drives its low output on and its high output off, whatever its high command is. Low command 0 with high command 0 requests the high output. Low command 0 with high command 1 requests neither output.
- R3: An output that is no longer requested falls on the third rising edge after the input change: two edges of synchronizer, then one output register.
- R4: With bypass off and a stored length D, a newly requested output rises on rising edge D+3 after the input change. When D is 0, it rises on the third edge, on the same edge where the opposite output falls.
- R5: With bypass off, the low and high outputs of a phase are never 1 in the same cycle.
- R6: If the request of a phase switches to the other output before its count ends, the count restarts from the full length D. The new output then rises D+3 edges after the second change, and the abandoned output never rises.
- R7: With bypass on, the low output equals the low command and the high output equals the inverse of the high command. The latency is 3 edges and there is no dead time, so both outputs may be 1 together.
- R8: A 1 on the disable input or on the undervoltage input forces all six outputs to 0 within 3 edges. This overrides bypass and every command.
- R9: The stored dead-time length is loaded from the dead-time input only on an edge where all six outputs were 0 before the edge. A change made while any output is on leaves a running or later count unchanged until all outputs have been off.
- R10: The three phases are independent. Each has its own counter, and a request on one phase does not change the outputs of another.
- R11: With the high command held at 0, toggling the low command alone gives complementary drive of the two outputs, with D cycles of dead time before each rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dis_in | input | 1 | Global disable; 1 forces all outputs off |
| uv_flag | input | 1 | Undervoltage indication; 1 forces all outputs off |
| dt_bypass | input | 1 | 1 selects direct follow mode with no dead time |
| dt_cycles | input | DT_W | Dead-time length in clock cycles |
| lo_cmd | input | NPHASE | Low-side command per phase, active high |
| hi_cmd_n | input | NPHASE | High-side command per phase, active low |
| lo_gate | output | NPHASE | Low-side gate enable per phase |
| hi_gate | output | NPHASE | High-side gate enable per phase |

## Verification
The bench builds the block with NPHASE=3, DT_W=6 and DT_RESET=2. The narrow length field makes the largest dead time, 63 cycles, short enough to test, and the test counts up to that rise edge by edge. The small reset length lets the tests that start straight after reset run quickly. Lengths of 0, 3, 5, 6 and 10 cover the immediate swap, the exact rise edge, a restart partway through a count, and a length change while an output is on, which must wait for all outputs to be off.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_LO   = 2'd1,
        PEND_HI   = 2'd2
    } pend_e;

    typedef struct packed {
        logic lo;
        logic hi_n;
    } phase_cmd_t;

    typedef struct packed {
        logic lo;
        logic hi;
    } gate_pair_t;

    typedef struct packed {
        logic kill;
        logic bypass;
    } ctrl_t;

    localparam ctrl_t CTRL_SAFE = '{kill: 1'b1, bypass: 1'b0};

    // Requested gate pair for one phase, before any dead-time delay.
    function automatic gate_pair_t resolve_cmd(phase_cmd_t c, logic bypass, logic kill);
        gate_pair_t g;
        if (kill) begin
            g.lo = 1'b0;
            g.hi = 1'b0;
        end else if (bypass) begin
            g.lo = c.lo;
            g.hi = ~c.hi_n;
        end else begin
            g.lo = c.lo;
            g.hi = ~c.lo & ~c.hi_n;
        end
        return g;
    endfunction

endpackage

// File: rtl/dtc_sync.sv
module dtc_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dtc_dt_hold.sv
module dtc_dt_hold #(
    parameter int DT_W     = 8,
    parameter int DT_RESET = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            all_off,
    input  logic [DT_W-1:0] dt_in,
    output logic [DT_W-1:0] dt_q
);
    localparam logic [DT_W-1:0] DT_RST = DT_W'(DT_RESET);

    always_ff @(posedge clk) begin
        if (rst)          dt_q <= DT_RST;
        else if (all_off) dt_q <= dt_in;
    end

    AST_DT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(all_off) |-> $stable(dt_q)); // R9
endmodule

// File: rtl/dtc_phase.sv
module dtc_phase
    import dtc_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  phase_cmd_t      cmd,
    input  logic            bypass,
    input  logic            kill,
    input  logic [DT_W-1:0] dt_len,
    output gate_pair_t      gate
);
    gate_pair_t      want;
    gate_pair_t      gate_q;
    pend_e           pend;
    logic [DT_W-1:0] cnt;
    logic            want_lo;
    logic            want_hi;

    assign want    = resolve_cmd(cmd, bypass, kill);
    assign want_lo = want.lo;
    assign want_hi = want.hi;
    assign gate    = gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
            pend   <= PEND_NONE;
            cnt    <= '0;
        end else if (kill || bypass) begin
            gate_q <= want;
            pend   <= PEND_NONE;
            cnt    <= '0;
        end else begin
            // turn-off is immediate; turn-on below
            gate_q.lo <= gate_q.lo & want_lo;
            gate_q.hi <= gate_q.hi & want_hi;
            pend      <= PEND_NONE;
            cnt       <= '0;
            if (want_lo && !gate_q.lo) begin
                if (pend != PEND_LO) begin
                    if (dt_len == '0) begin
                        gate_q.lo <= 1'b1;
                    end else begin
                        pend <= PEND_LO;
                        cnt  <= dt_len - 1'b1;
                    end
                end else if (cnt == '0) begin
                    gate_q.lo <= 1'b1;
                end else begin
                    pend <= PEND_LO;
                    cnt  <= cnt - 1'b1;
                end
            end else if (want_hi && !gate_q.hi) begin
                if (pend != PEND_HI) begin
                    if (dt_len == '0) begin
                        gate_q.hi <= 1'b1;
                    end else begin
                        pend <= PEND_HI;
                        cnt  <= dt_len - 1'b1;
                    end
                end else if (cnt == '0) begin
                    gate_q.hi <= 1'b1;
                end else begin
                    pend <= PEND_HI;
                    cnt  <= cnt - 1'b1;
                end
            end
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !$past(bypass) |-> !(gate_q.lo && gate_q.hi)); // R5
    AST_LO_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (!$past(bypass) && $past(cmd.lo)) |-> !gate_q.hi); // R2
    AST_FAST_OFF: assert property (@(posedge clk) disable iff (rst)
        (!$past(want_lo) |-> !gate_q.lo) and (!$past(want_hi) |-> !gate_q.hi)); // R3
    AST_KILL_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(kill) |-> (gate_q == '0)); // R8
    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        ($past(bypass) && !$past(kill)) |->
        (gate_q.lo == $past(cmd.lo)) && (gate_q.hi == !$past(cmd.hi_n))); // R7
endmodule

// File: rtl/bridge_deadtime_ctrl.sv
module bridge_deadtime_ctrl
    import dtc_pkg::*;
#(
    parameter int NPHASE   = 3,
    parameter int DT_W     = 8,
    parameter int DT_RESET = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dis_in,
    input  logic              uv_flag,
    input  logic              dt_bypass,
    input  logic [DT_W-1:0]   dt_cycles,
    input  logic [NPHASE-1:0] lo_cmd,
    input  logic [NPHASE-1:0] hi_cmd_n,
    output logic [NPHASE-1:0] lo_gate,
    output logic [NPHASE-1:0] hi_gate
);
    logic [NPHASE-1:0] lo_s;
    logic [NPHASE-1:0] hin_s;
    ctrl_t             ctrl_raw;
    ctrl_t             ctrl_s;
    logic [DT_W-1:0]   dt_len;
    logic              all_off;

    assign ctrl_raw.kill   = dis_in | uv_flag;
    assign ctrl_raw.bypass = dt_bypass;

    dtc_sync #(.W(NPHASE), .RST_VAL({NPHASE{1'b0}})) u_sync_lo (
        .clk(clk), .rst(rst), .d(lo_cmd), .q(lo_s));

    dtc_sync #(.W(NPHASE), .RST_VAL({NPHASE{1'b1}})) u_sync_hi (
        .clk(clk), .rst(rst), .d(hi_cmd_n), .q(hin_s));

    dtc_sync #(.W($bits(ctrl_t)), .RST_VAL(CTRL_SAFE)) u_sync_ctrl (
        .clk(clk), .rst(rst), .d(ctrl_raw), .q(ctrl_s));

    assign all_off = ~(|lo_gate) & ~(|hi_gate);

    dtc_dt_hold #(.DT_W(DT_W), .DT_RESET(DT_RESET)) u_dt_hold (
        .clk(clk), .rst(rst), .all_off(all_off), .dt_in(dt_cycles), .dt_q(dt_len));

    for (genvar p = 0; p < NPHASE; p++) begin : g_phase
        phase_cmd_t cmd_p;
        gate_pair_t gate_p;

        assign cmd_p.lo   = lo_s[p];
        assign cmd_p.hi_n = hin_s[p];

        dtc_phase #(.DT_W(DT_W)) u_phase (
            .clk(clk), .rst(rst), .cmd(cmd_p), .bypass(ctrl_s.bypass),
            .kill(ctrl_s.kill), .dt_len(dt_len), .gate(gate_p));

        assign lo_gate[p] = gate_p.lo;
        assign hi_gate[p] = gate_p.hi;
    end

    AST_RESET_OFF: assert property (@(posedge clk)
        $past(rst) |-> (lo_gate == '0) && (hi_gate == '0)); // R1
endmodule

// File: tb/bridge_deadtime_ctrl_bench.sv
`timescale 1ns/1ps
module bridge_deadtime_ctrl_bench;
    localparam int NP = 3;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          dis_in, uv_flag, dt_bypass;
    logic [DW-1:0] dt_cycles;
    logic [NP-1:0] lo_cmd, hi_cmd_n;
    logic [NP-1:0] lo_gate, hi_gate;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bridge_deadtime_ctrl #(.NPHASE(NP), .DT_W(DW), .DT_RESET(2)) u_bridge_deadtime_ctrl (
        .clk(clk), .rst(rst), .dis_in(dis_in), .uv_flag(uv_flag),
        .dt_bypass(dt_bypass), .dt_cycles(dt_cycles), .lo_cmd(lo_cmd),
        .hi_cmd_n(hi_cmd_n), .lo_gate(lo_gate), .hi_gate(hi_gate));

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [NP-1:0] lo_exp, input logic [NP-1:0] hi_exp);
        checks++;
        if (lo_gate !== lo_exp || hi_gate !== hi_exp) begin
            errors++;
            $display("FAIL %s: lo=%b hi=%b expected lo=%b hi=%b", req, lo_gate, hi_gate, lo_exp, hi_exp);
        end
    endtask

    task automatic clear_all();
        lo_cmd = '0; hi_cmd_n = '1; dis_in = 0; uv_flag = 0; dt_bypass = 0;
        step(4);
    endtask

    task automatic t_reset();
        rst = 1; dis_in = 0; uv_flag = 0; dt_bypass = 0; dt_cycles = 6'd2;
        lo_cmd = '1; hi_cmd_n = '0;
        step(2);
        chk("R1 during reset", 3'b000, 3'b000);
        lo_cmd = '0; hi_cmd_n = '1;
        rst = 0;
        step(1);
        chk("R1 after reset", 3'b000, 3'b000);
        // reset length 2 is used by the first request before any resample matters
        lo_cmd = 3'b001;
        step(4);
        chk("R1 reset length 2 not yet", 3'b000, 3'b000);
        step(1);
        chk("R1 reset length 2 rise", 3'b001, 3'b000);
        clear_all();
    endtask

    task automatic t_priority();
        dt_cycles = 6'd2;
        lo_cmd = 3'b001; hi_cmd_n = 3'b110;
        step(5);
        chk("R2 low wins over high", 3'b001, 3'b000);
        lo_cmd = 3'b000; hi_cmd_n = 3'b111;
        step(3);
        chk("R2 no request both off", 3'b000, 3'b000);
        hi_cmd_n = 3'b110;
        step(5);
        chk("R2 high request on", 3'b000, 3'b001);
        clear_all();
    endtask

    task automatic t_timing();
        dt_cycles = 6'd5;
        lo_cmd = 3'b010;
        step(7);
        chk("R4 low not before D+3", 3'b000, 3'b000);
        step(1);
        chk("R4 low at D+3", 3'b010, 3'b000);
        lo_cmd = 3'b000; hi_cmd_n = 3'b101;
        step(2);
        chk("R3 low still on at edge 2", 3'b010, 3'b000);
        step(1);
        chk("R3 low off at edge 3", 3'b000, 3'b000);
        step(4);
        chk("R5 gap both off", 3'b000, 3'b000);
        step(1);
        chk("R4 high at D+3", 3'b000, 3'b010);
        clear_all();
    endtask

    task automatic t_restart();
        dt_cycles = 6'd6;
        lo_cmd = 3'b001;
        step(3);
        lo_cmd = 3'b000; hi_cmd_n = 3'b110;
        step(8);
        chk("R6 restarted count not done", 3'b000, 3'b000);
        step(1);
        chk("R6 high at full D after change", 3'b000, 3'b001);
        clear_all();
    endtask

    task automatic t_complementary();
        dt_cycles = 6'd3;
        hi_cmd_n = 3'b011; lo_cmd = 3'b100;
        step(6);
        chk("R11 low phase on", 3'b100, 3'b000);
        lo_cmd = 3'b000;
        step(3);
        chk("R11 low off, high waits", 3'b000, 3'b000);
        step(3);
        chk("R11 high on after D", 3'b000, 3'b100);
        lo_cmd = 3'b100;
        step(3);
        chk("R11 high off at once", 3'b000, 3'b000);
        step(3);
        chk("R11 low back on", 3'b100, 3'b000);
        clear_all();
    endtask

    task automatic t_bypass();
        dt_cycles = 6'd5;
        dt_bypass = 1;
        step(3);
        lo_cmd = 3'b011; hi_cmd_n = 3'b010;
        step(2);
        chk("R7 not before edge 3", 3'b000, 3'b000);
        step(1);
        chk("R7 follow both on", 3'b011, 3'b101);
        lo_cmd = 3'b000; hi_cmd_n = 3'b111;
        step(3);
        chk("R7 follow off", 3'b000, 3'b000);
        lo_cmd = 3'b001; hi_cmd_n = 3'b110;
        step(3);
        chk("R7 overlap allowed", 3'b001, 3'b001);
        dt_bypass = 0;
        step(3);
        chk("R5 leaving bypass drops high", 3'b001, 3'b000);
        clear_all();
    endtask

    task automatic t_kill();
        dt_cycles = 6'd3;
        dt_bypass = 1;
        lo_cmd = 3'b111; hi_cmd_n = 3'b000;
        step(3);
        dis_in = 1;
        step(3);
        chk("R8 disable overrides bypass", 3'b000, 3'b000);
        dis_in = 0; uv_flag = 1;
        step(6);
        chk("R8 undervoltage keeps off", 3'b000, 3'b000);
        uv_flag = 0; dt_bypass = 0; hi_cmd_n = 3'b111;
        step(5);
        chk("R8 release waits dead time", 3'b000, 3'b000);
        step(1);
        chk("R8 release then on", 3'b111, 3'b000);
        uv_flag = 1;
        step(3);
        chk("R8 undervoltage off in dt mode", 3'b000, 3'b000);
        clear_all();
    endtask

    task automatic t_dt_sample();
        dt_cycles = 6'd3;
        lo_cmd = 3'b001;
        step(6);
        chk("R9 low on with D=3", 3'b001, 3'b000);
        dt_cycles = 6'd10;
        lo_cmd = 3'b000; hi_cmd_n = 3'b110;
        step(5);
        chk("R9 old length still counting", 3'b000, 3'b000);
        step(1);
        chk("R9 running count not changed", 3'b000, 3'b001);
        clear_all();
        lo_cmd = 3'b010;
        step(12);
        chk("R9 new length not done", 3'b000, 3'b000);
        step(1);
        chk("R9 new length applied", 3'b010, 3'b000);
        clear_all();
    endtask

    task automatic t_bounds();
        dt_cycles = 6'd63;
        lo_cmd = 3'b100;
        step(65);
        chk("R4 max length not done", 3'b000, 3'b000);
        step(1);
        chk("R4 max length rise", 3'b100, 3'b000);
        clear_all();
        dt_cycles = 6'd0;
        lo_cmd = 3'b100;
        step(3);
        chk("R4 zero length immediate", 3'b100, 3'b000);
        lo_cmd = 3'b000; hi_cmd_n = 3'b011;
        step(3);
        chk("R4 zero length swap same edge", 3'b000, 3'b100);
        clear_all();
    endtask

    task automatic t_indep();
        dt_cycles = 6'd4;
        lo_cmd = 3'b001; hi_cmd_n = 3'b011;
        step(6);
        chk("R10 phases wait", 3'b000, 3'b000);
        step(1);
        chk("R10 phase A low and C high", 3'b001, 3'b100);
        lo_cmd = 3'b011;
        step(3);
        chk("R10 phase B counts alone", 3'b001, 3'b100);
        step(4);
        chk("R10 phase B on, others kept", 3'b011, 3'b100);
        clear_all();
    endtask

    initial begin
        #600000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_priority();
        t_timing();
        t_restart();
        t_complementary();
        t_bypass();
        t_kill();
        t_dt_sample();
        t_bounds();
        t_indep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule